// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block gathers thirty-two level-sensitive interrupt sources and folds them into four parent interrupt lines, one line per group of eight neighbouring sources. Each source has its own enable bit. A group line is asserted while at least one enabled source of that group is high. It is registered, so it follows the sources one clock later.

Software reaches the enables through a small register bank on a simple bus: a byte address, write data, a write strobe and a combinational read-data return. Enables are never written as a whole word. One register sets the enable bits wherever the write data holds a 1. Another register clears the enable bits wherever the write data holds a 1. Bits written as 0 leave the enables alone, so two drivers sharing the bank cannot undo each other's changes. A third register returns the raw sources gated by their enables. A group is disabled by writing its whole byte to the clear register.

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable bit is 0 and all four group outputs are 0. A source that is high has no effect until it is enabled.
- R2: A write to byte address 0x0 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to byte address 0x4 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: Reading byte address 0xC returns the bitwise AND of the raw source lines and the enable word, combinationally from the current inputs.
- R5: Reading address 0x0 or 0x4 returns the current enable word. Any other address reads 0, including 0x8 and addresses whose two low bits are not 0. A write to any other address leaves the enables unchanged.
- R6: Group output g (g = 0..3) is the OR of source bits [8g+7:8g] ANDed with their enables, as sampled at the previous clock edge.
- R7: A change of source or enable in one group never changes another group's output.
- R8: Writing 0xFF into the byte of one group through the clear register turns that group's output off. The other groups keep their enables.
- R9: A group output stays asserted while an enabled source is held high. It falls at the first edge after that source goes low or is disabled. An enable write and a source change in the same cycle both take effect at the same edge, and the output sees the new enable one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw level interrupt sources |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| grp_irq | output | 4 | One parent interrupt line per group |

## Verification
Two things can land in the same clock edge: an enable update from a set or clear write, and a change on the source lines that feeds the registered group outputs. The bench provokes this on purpose. In one case it clears a group's enables in the same cycle that the group's sources rise. It then checks that the output for the next cycle is computed from the old enable and that the output falls one edge later. A behavioural model, updated at every edge, judges random mixes of writes, reads and source patterns against both the read data and the four group lines.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    // Register selector taken from address bits [3:2].
    typedef enum logic [1:0] {
        SEL_SET  = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_GAP  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/cmb_enable.sv
module cmb_enable #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] en_word
);

    typedef struct packed {
        logic [SRC_W-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // The set is applied first and the clear second, so a clear always wins.
        if (set_stb) st_d.en = st_d.en | wdata;
        if (clr_stb) st_d.en = st_d.en & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_word = st_q.en;

endmodule

// File: rtl/cmb_group.sv
module cmb_group #(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    localparam int SRC_W  = NUM_GRP * GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   src,
    input  logic [SRC_W-1:0]   en,
    output logic [NUM_GRP-1:0] grp_out
);

    typedef struct packed {
        logic [NUM_GRP-1:0] line;
    } grp_state_t;

    grp_state_t         st_d, st_q;
    logic [NUM_GRP-1:0] any_active;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_reduce
        assign any_active[g] = |(src[g*GRP_W +: GRP_W] & en[g*GRP_W +: GRP_W]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.line = any_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grp_out = st_q.line;

endmodule

// File: rtl/cmb_readmux.sv
module cmb_readmux
    import cmb_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             hit,
    input  reg_sel_e         sel,
    input  logic [SRC_W-1:0] src,
    input  logic [SRC_W-1:0] en,
    output logic [SRC_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_SET, SEL_CLR: rdata = en;
                SEL_STAT:         rdata = src & en;
                default:          rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import cmb_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = 4,
    localparam int SRC_W  = NUM_GRP * GRP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [SRC_W-1:0]   bus_wdata,
    input  logic               bus_wr,
    output logic [SRC_W-1:0]   bus_rdata,
    output logic [NUM_GRP-1:0] grp_irq
);

    logic             word_hit;
    reg_sel_e         sel;
    logic             set_stb;
    logic             clr_stb;
    logic [SRC_W-1:0] enable_word;

    // Only aligned word accesses reach a register.
    assign word_hit = (bus_addr[1:0] == 2'b00);
    assign sel      = reg_sel_e'(bus_addr[3:2]);
    assign set_stb  = bus_wr && word_hit && (sel == SEL_SET);
    assign clr_stb  = bus_wr && word_hit && (sel == SEL_CLR);

    cmb_enable #(.SRC_W(SRC_W)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .wdata   (bus_wdata),
        .en_word (enable_word)
    );

    cmb_group #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_group (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src_i),
        .en      (enable_word),
        .grp_out (grp_irq)
    );

    cmb_readmux #(.SRC_W(SRC_W)) u_rdmux (
        .hit   (word_hit),
        .sel   (sel),
        .src   (src_i),
        .en    (enable_word),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/cmb_checker.sv
module cmb_checker #(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 8,
    parameter int ADDR_W  = 4,
    localparam int SRC_W  = NUM_GRP * GRP_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SRC_W-1:0]   src_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [SRC_W-1:0]   bus_wdata,
    input logic               bus_wr,
    input logic [SRC_W-1:0]   bus_rdata,
    input logic [NUM_GRP-1:0] grp_irq,
    input logic [SRC_W-1:0]   en
);

    logic wr_set;
    logic wr_clr;
    assign wr_set = bus_wr && (bus_addr == 4'h0);
    assign wr_clr = bus_wr && (bus_addr == 4'h4);

    // R1: nothing is enabled or asserted in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en == '0 && grp_irq == '0));

    // R2: a set write turns on the 1-bits and keeps the rest.
    p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en & $past(bus_wdata)) == $past(bus_wdata)) &&
                   ((en & ~$past(bus_wdata)) == ($past(en) & ~$past(bus_wdata))));

    // R3: a clear write turns off the 1-bits and keeps the rest.
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en & $past(bus_wdata)) == '0) &&
                   ((en & ~$past(bus_wdata)) == ($past(en) & ~$past(bus_wdata))));

    // R4: the status read is the gated source word.
    p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'hC) |-> (bus_rdata == (src_i & en)));

    // R5: no other write moves the enables.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(en));

    // R6: each group line follows its gated sources one edge later.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        p_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (grp_irq[g] == $past(|(src_i[g*GRP_W +: GRP_W] & en[g*GRP_W +: GRP_W]))));
    end

endmodule

bind irq_combiner cmb_checker #(
    .NUM_GRP (NUM_GRP),
    .GRP_W   (GRP_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq),
    .en        (enable_word)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        wr;
    logic [31:0] rdata;
    logic [3:0]  grp_irq;

    always #5 clk = ~clk;

    irq_combiner uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_wr    (wr),
        .bus_rdata (rdata),
        .grp_irq   (grp_irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Behavioural reference state.
    logic [31:0] en_m;
    logic [3:0]  irq_m;

    function automatic logic [3:0] any_in_group(input logic [31:0] v);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = (v[g*8 +: 8] != 8'h00);
        return r;
    endfunction

    function automatic logic [31:0] expect_read(input logic [3:0] a);
        case (a)
            4'h0, 4'h4: return en_m;
            4'hC:       return src & en_m;
            default:    return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_m  <= '0;
            irq_m <= '0;
        end else begin
            irq_m <= any_in_group(src & en_m);
            if (wr && addr == 4'h0)      en_m <= en_m | wdata;
            else if (wr && addr == 4'h4) en_m <= en_m & ~wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 group lines vs model", {28'h0, grp_irq}, {28'h0, irq_m});
            check((addr == 4'hC) ? "R4 status vs model" : "R5 readback vs model",
                  rdata, expect_read(addr));
        end
    end

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        wr    = w;
        addr  = a;
        wdata = d;
    endtask

    task automatic peek(input string tag, input logic [3:0] a, input logic [31:0] exp);
        step(1'b0, a, 32'h0);
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic grp_is(input string tag, input logic [3:0] exp);
        #1;
        check(tag, {28'h0, grp_irq}, {28'h0, exp});
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        src   = 32'h0;
        addr  = 4'h0;
        wdata = 32'h0;
        wr    = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 enable word in reset", rdata, 32'h0);
        check("R1 group lines in reset", {28'h0, grp_irq}, 32'h0);
        rst_n = 1'b1;

        // R1: sources high but nothing enabled.
        step(1'b0, 4'h0, 32'h0); src = 32'hFFFF_FFFF;
        step(1'b0, 4'h0, 32'h0);
        step(1'b0, 4'h0, 32'h0);
        grp_is("R1 no enable no output", 4'b0000);

        // R2: set one bit in group 0 and one in group 1.
        step(1'b1, 4'h0, 32'h0000_0101);
        step(1'b0, 4'h0, 32'h0);
        step(1'b0, 4'h0, 32'h0);
        grp_is("R6 groups 0 and 1 on", 4'b0011);
        peek("R2 set bits", 4'h0, 32'h0000_0101);
        step(1'b1, 4'h0, 32'h0);
        peek("R2 zero set keeps enables", 4'h0, 32'h0000_0101);

        // R3: clear bit 0, zero clear keeps.
        step(1'b1, 4'h4, 32'h0000_0001);
        peek("R3 clear bit", 4'h0, 32'h0000_0100);
        step(1'b1, 4'h4, 32'h0);
        peek("R3 zero clear keeps enables", 4'h4, 32'h0000_0100);

        // R4: status is raw AND enable.
        step(1'b1, 4'h0, 32'hFFFF_FFFF); src = 32'hA500_00F0;
        peek("R4 status gated", 4'hC, 32'hA500_00F0);
        step(1'b1, 4'h4, 32'h0000_00C0);
        peek("R4 status after partial clear", 4'hC, 32'hA500_0030);
        step(1'b1, 4'h0, 32'h0000_00C0);

        // R5: other addresses are inert and read 0.
        step(1'b1, 4'h8, 32'h0);
        step(1'b1, 4'hC, 32'h0);
        step(1'b1, 4'h5, 32'hFFFF_FFFF);
        step(1'b1, 4'h6, 32'hFFFF_FFFF);
        peek("R5 stray writes ignored", 4'h0, 32'hFFFF_FFFF);
        peek("R5 gap reads zero", 4'h8, 32'h0);
        peek("R5 misaligned reads zero", 4'h6, 32'h0);

        // R8: whole-byte clear turns group 2 off.
        step(1'b0, 4'h0, 32'h0); src = 32'hFFFF_FFFF;
        step(1'b1, 4'h4, 32'h00FF_0000);
        step(1'b0, 4'h0, 32'h0);
        step(1'b0, 4'h0, 32'h0);
        grp_is("R8 group 2 disabled", 4'b1011);
        peek("R8 other groups kept", 4'h0, 32'hFF00_FFFF);

        // R7: group 0 activity leaves groups 1 and 3 alone.
        step(1'b0, 4'h0, 32'h0); src = 32'hFFFF_FF00;
        step(1'b0, 4'h0, 32'h0);
        grp_is("R7 only group 0 drops", 4'b1010);
        step(1'b0, 4'h0, 32'h0); src = 32'hFFFF_FFFF;
        step(1'b0, 4'h0, 32'h0);
        grp_is("R7 group 0 back, others steady", 4'b1011);

        // R9: level held stays, release falls one edge later.
        repeat (5) step(1'b0, 4'h0, 32'h0);
        grp_is("R9 held level stays", 4'b1011);
        step(1'b0, 4'h0, 32'h0); src = 32'h0;
        step(1'b0, 4'h0, 32'h0);
        grp_is("R9 release falls", 4'b0000);

        // R9: enable clear and source rise at the same edge.
        step(1'b1, 4'h4, 32'hFF00_0000); src = 32'hFFFF_FFFF;
        step(1'b0, 4'h0, 32'h0);
        grp_is("R9 same-edge uses old enable", 4'b1011);
        step(1'b0, 4'h0, 32'h0);
        grp_is("R9 new enable one edge later", 4'b0011);

        // Random mix, judged by the per-cycle model.
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            case ($urandom % 6)
                0, 1:    a = 4'h0;
                2, 3:    a = 4'h4;
                4:       a = 4'hC;
                default: a = 4'(($urandom % 4) * 4 + ($urandom % 2));
            endcase
            step(1'($urandom % 2), a, $urandom & $urandom);
            src = $urandom;
        end

        step(1'b0, 4'h0, 32'h0);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule